// File: doc/BRIEF.md
# Permuted DRAM Bank Mapper with Row Tracking

This block takes one physical memory request at a time and works out where it lands in a banked DRAM: the column (the offset within a row), the row (page) and the bank. The bank is not taken directly from the address. The bank field is XORed with the low bits of the field that a second-level cache would treat as its tag. As a result, addresses that collide in the cache are spread across different banks. Addresses inside one page still stay together in one bank.

The block keeps an open-row record for every bank. Each request falls into one of three classes:
- a row hit,
- a miss on a precharged (closed) bank,
- a conflict with a different open row.

After accepting a request, the block waits the latency that belongs to its class. It then pulses `done` with the mapped coordinates and the class. Every access leaves its row open in its bank (open-page policy). A separate close input precharges a chosen bank.

A three-state machine controls the flow:
- **ST_IDLE**: the block raises `req_ready`. An accepted request (`req_valid` high while `req_ready` is high) moves it to ST_WAIT.
- **ST_WAIT**: the latency timer counts. When the timer expires, the block moves to ST_DONE.
- **ST_DONE**: `done` is high for one cycle. The block then returns to ST_IDLE.

Top module: `dbm_mapper`

## Requirements
- R1: `done_col` equals address bits [COL_W-1:0]. `done_row` equals the address bits above the bank field, [ADDR_W-1:COL_W+BANK_W]. Both pass through unchanged.
- R2: `done_bank` equals address bits [COL_W+BANK_W-1:COL_W] XOR address bits [TAG_LSB+BANK_W-1:TAG_LSB]. Defaults: COL_W=11, BANK_W=5, TAG_LSB=18.
- R3: Two addresses that differ only in their column bits map to the same bank.
- R4: Two addresses with the same bank field whose low tag bits differ map to different banks.
- R5: The class is encoded as 0 = hit, 1 = closed, 2 = conflict.
  - A request is a hit when its bank holds its row open.
  - It is closed when the bank has no open row.
  - It is a conflict when the bank holds a different row.
  - After the access, that bank holds the accessed row open.
- R6: `done` rises exactly HIT_CYC, CLOSED_CYC or CONFLICT_CYC rising edges (defaults 4, 8, 14) after the accepting edge, according to the class.
- R7: `req_ready` is low from the accepting edge until `done` falls. It is high again in the cycle after the `done` cycle.
- R8: `done` lasts exactly one cycle. In that cycle it carries the bank, row, column and class of the request.
- R9: `close_en` with `close_bank` precharges that bank, so the next request to it is closed. Closing a bank has no effect on any other bank.
- R10: After reset, `req_ready` is high, `done` is low and every bank is precharged.
- R11: A close of the same bank on the accepting edge does not change the request's class. That class comes from the state before the edge, and the bank is left open with the new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W | Physical request address |
| close_en | input | 1 | Precharge the bank given by close_bank |
| close_bank | input | BANK_W | Bank to precharge |
| done | output | 1 | One-cycle completion pulse |
| done_bank | output | BANK_W | Permuted bank of the completed request |
| done_row | output | ADDR_W-COL_W-BANK_W | Row of the completed request |
| done_col | output | COL_W | Column of the completed request |
| done_class | output | 2 | Row-buffer class (0 hit, 1 closed, 2 conflict) |

## Verification
The hardest situation to reach from the ports is a conflict whose address has a different bank field from the row that is already open. The permutation has to fold two distinct bank fields onto one bank. The stimulus table builds such pairs on purpose: the row's low bits feed the tag slice, so a chosen row combined with a chosen bank field lands on an already-open bank. Each table entry's bank is then checked against the XOR formula. A second awkward case is a close that coincides with an accepted request to the same bank. A dedicated request task drives both on the same edge.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    typedef enum logic [1:0] {
        RB_HIT      = 2'd0,
        RB_CLOSED   = 2'd1,
        RB_CONFLICT = 2'd2
    } rb_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } dbm_state_e;

endpackage

// File: rtl/dbm_addr_split.sv
module dbm_addr_split #(
    parameter int ADDR_W  = 32,
    parameter int COL_W   = 11,
    parameter int BANK_W  = 5,
    parameter int TAG_LSB = 18,
    parameter int ROW_W   = ADDR_W - COL_W - BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);

    localparam int BF_LSB = COL_W;
    localparam int RW_LSB = COL_W + BANK_W;

    logic [BANK_W-1:0] bank_field;
    logic [BANK_W-1:0] tag_low;

    // The tag slice must sit above the column so that a page never splits across banks.
    generate
        if (TAG_LSB < COL_W || TAG_LSB + BANK_W > ADDR_W) begin : g_bad_geom
            $error("tag slice must lie above the column field and inside the address");
        end
    endgenerate

    assign col        = addr[COL_W-1:0];
    assign bank_field = addr[RW_LSB-1:BF_LSB];
    assign tag_low    = addr[TAG_LSB+BANK_W-1:TAG_LSB];
    assign row        = addr[ADDR_W-1:RW_LSB];
    assign bank       = bank_field ^ tag_low;

endmodule

// File: rtl/dbm_row_table.sv
module dbm_row_table
    import dbm_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int ROW_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output rb_class_e         lk_class,
    input  logic              upd_en,
    input  logic              close_en,
    input  logic [BANK_W-1:0] close_bank
);

    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    open_q[b] <= 1'b0;
                    row_q[b]  <= '0;
                end else if (upd_en && lk_bank == BANK_W'(b)) begin
                    open_q[b] <= 1'b1;
                    row_q[b]  <= lk_row;
                end else if (close_en && close_bank == BANK_W'(b)) begin
                    open_q[b] <= 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        if (!open_q[lk_bank]) begin
            lk_class = RB_CLOSED;
        end else if (row_q[lk_bank] == lk_row) begin
            lk_class = RB_HIT;
        end else begin
            lk_class = RB_CONFLICT;
        end
    end

    AST_OPEN_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> open_q[$past(lk_bank)]); // R5

    AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (close_en && !(upd_en && lk_bank == close_bank)) |=> !open_q[$past(close_bank)]); // R9

endmodule

// File: rtl/dbm_lat_timer.sv
module dbm_lat_timer #(
    parameter int MAX_LAT = 14,
    parameter int CNT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_val - 1'b1;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire = busy_q && (cnt_q == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CNT_W'(MAX_LAT))); // R6

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R6

endmodule

// File: rtl/dbm_mapper.sv
module dbm_mapper
    import dbm_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int BANK_W       = 5,
    parameter int COL_W        = 11,
    parameter int TAG_LSB      = 18,
    parameter int HIT_CYC      = 4,
    parameter int CLOSED_CYC   = 8,
    parameter int CONFLICT_CYC = 14
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic                             close_en,
    input  logic [BANK_W-1:0]                close_bank,
    output logic                             done,
    output logic [BANK_W-1:0]                done_bank,
    output logic [ADDR_W-COL_W-BANK_W-1:0]   done_row,
    output logic [COL_W-1:0]                 done_col,
    output logic [1:0]                       done_class
);

    localparam int ROW_W    = ADDR_W - COL_W - BANK_W;
    localparam int MAX_LAT0 = (HIT_CYC > CLOSED_CYC) ? HIT_CYC : CLOSED_CYC;
    localparam int MAX_LAT  = (MAX_LAT0 > CONFLICT_CYC) ? MAX_LAT0 : CONFLICT_CYC;
    localparam int CNT_W    = $clog2(MAX_LAT + 1);

    dbm_state_e state_q, state_d;

    logic [COL_W-1:0]  map_col;
    logic [BANK_W-1:0] map_bank;
    logic [ROW_W-1:0]  map_row;
    rb_class_e         map_class;
    logic [CNT_W-1:0]  lat_val;
    logic              accept;
    logic              expire;

    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    rb_class_e         class_q;

    dbm_addr_split #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .TAG_LSB(TAG_LSB),
        .ROW_W  (ROW_W)
    ) u_split (
        .addr(req_addr),
        .col (map_col),
        .bank(map_bank),
        .row (map_row)
    );

    dbm_row_table #(
        .BANK_W(BANK_W),
        .ROW_W (ROW_W)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_bank   (map_bank),
        .lk_row    (map_row),
        .lk_class  (map_class),
        .upd_en    (accept),
        .close_en  (close_en),
        .close_bank(close_bank)
    );

    dbm_lat_timer #(
        .MAX_LAT(MAX_LAT),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(lat_val),
        .expire  (expire)
    );

    always_comb begin
        unique case (map_class)
            RB_HIT:    lat_val = CNT_W'(HIT_CYC);
            RB_CLOSED: lat_val = CNT_W'(CLOSED_CYC);
            default:   lat_val = CNT_W'(CONFLICT_CYC);
        endcase
    end

    assign accept = req_valid && req_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_WAIT;
            ST_WAIT: if (expire) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            class_q <= RB_HIT;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bank_q  <= map_bank;
                row_q   <= map_row;
                col_q   <= map_col;
                class_q <= map_class;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        done       = (state_q == ST_DONE);
        done_bank  = bank_q;
        done_row   = row_q;
        done_col   = col_q;
        done_class = class_q;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R7

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R7

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R7

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(accept)) |-> ($stable(done_bank) && $stable(done_row))); // R8

endmodule

// File: tb/dbm_mapper_tb.sv
module dbm_mapper_tb;

    localparam int NV = 10;
    localparam logic [31:0] VEC_ADDR [NV] = '{
        32'h0000_1810, 32'h0000_1FFF, 32'h0004_1810, 32'h0008_0800, 32'h0000_1800,
        32'h0004_1805, 32'h007C_F800, 32'hFFFF_0000, 32'hFFFF_0123, 32'h0001_0000
    };
    // expected class: 0 hit, 1 closed, 2 conflict
    localparam logic [1:0] VEC_CLS [NV] = '{
        2'd1, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1, 2'd1, 2'd0, 2'd2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        close_en = 1'b0;
    logic [4:0]  close_bank = '0;
    logic        done;
    logic [4:0]  done_bank;
    logic [15:0] done_row;
    logic [10:0] done_col;
    logic [1:0]  done_class;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dbm_mapper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .close_en  (close_en),
        .close_bank(close_bank),
        .done      (done),
        .done_bank (done_bank),
        .done_row  (done_row),
        .done_col  (done_col),
        .done_class(done_class)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : 14;
    endfunction

    // One request; optional close on the accepting edge.
    task automatic do_req(input logic [31:0] a, input logic [1:0] exp_cls,
                          input logic cl_en, input logic [4:0] cl_bank, input string tag);
        int lat;
        logic [4:0] exp_bank;
        exp_bank = a[15:11] ^ a[22:18];
        @(negedge clk);
        chk({tag, " R7 ready idle"}, req_ready, 1);
        req_valid  = 1'b1;
        req_addr   = a;
        close_en   = cl_en;
        close_bank = cl_bank;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        close_en  = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            if (req_ready) chk({tag, " R7 ready low while busy"}, req_ready, 0);
            @(posedge clk);
            #1;
            lat++;
        end
        chk({tag, " R6 latency"}, lat, lat_of(exp_cls));
        chk({tag, " R5 class"}, done_class, exp_cls);
        chk({tag, " R2 bank"}, done_bank, exp_bank);
        chk({tag, " R1 row"}, done_row, a[31:16]);
        chk({tag, " R1 col"}, done_col, a[10:0]);
        chk({tag, " R7 ready low in done"}, req_ready, 0);
        @(posedge clk);
        #1;
        chk({tag, " R8 done one cycle"}, done, 0);
        chk({tag, " R7 ready back"}, req_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 ready after reset", req_ready, 1);
        chk("R10 done after reset", done, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_req(VEC_ADDR[i], VEC_CLS[i], 1'b0, 5'd0, $sformatf("vec%0d", i));
        end

        // R3: same page -> same bank (vec0 vs vec1)
        chk("R3 same page same bank", VEC_ADDR[0][15:11] ^ VEC_ADDR[0][22:18],
            VEC_ADDR[1][15:11] ^ VEC_ADDR[1][22:18]);
        // R4: vec0 and vec2 share the bank field but their low tag bits differ; observed banks differ
        do_req(32'h0000_1810, 2'd0, 1'b0, 5'd0, "R4 first");
        chk("R4 bank of first", done_bank, 5'd3);
        do_req(32'h0004_1810, 2'd0, 1'b0, 5'd0, "R4 second");
        chk("R4 bank of second differs", done_bank, 5'd2);

        // R9: closing bank 3 precharges it
        @(negedge clk);
        close_en = 1'b1; close_bank = 5'd3;
        @(negedge clk);
        close_en = 1'b0;
        do_req(32'h0000_1800, 2'd1, 1'b0, 5'd0, "R9 closed bank");
        // R9: closing bank 1 leaves bank 2 open
        @(negedge clk);
        close_en = 1'b1; close_bank = 5'd1;
        @(negedge clk);
        close_en = 1'b0;
        do_req(32'h0004_1800, 2'd0, 1'b0, 5'd0, "R9 other bank kept");

        // R11: close on the accepting edge to the same bank
        do_req(32'hFFFF_0000, 2'd0, 1'b1, 5'd31, "R11 simultaneous");
        do_req(32'hFFFF_0000, 2'd0, 1'b0, 5'd0, "R11 left open");

        // R10: reset precharges every bank
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 ready in reset", req_ready, 1);
        chk("R10 done in reset", done, 0);
        rst_n = 1'b1;
        do_req(32'hFFFF_0000, 2'd1, 1'b0, 5'd0, "R10 banks closed");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule